// File: doc/BRIEF.md
# Gated Two-Source Descriptor Merger

This block sits in front of a copy engine. It takes descriptors from two places: the internal fetch path and an external bypass port. It merges them into one ordered stream. When both sources offer work in the same cycle, a round-robin pointer picks which one goes first. The pointer moves to the other source only after a grant has been taken. The merged stream leaves through a single-entry output stage that has a valid/ready handshake. A completion pulse from the downstream mover retires each issued descriptor, and an outstanding counter caps how many may be in the mover at once.

Software controls admission with a run-enable bit. While the bit is low, both inputs keep ready high and discard whatever arrives, so neither source ever stalls. Work that was admitted before the bit fell keeps going: a held output descriptor is still delivered, and outstanding completions are still counted. A quiesce output tells software when the engine has fully drained. Raising the bit again clears the pointer, the output stage, the counter and the error flag. A bypass descriptor whose queue is tagged as internal-mode is consumed, not forwarded, and raises a one-cycle error pulse.

Top module: `desc_merge_gate`

## Requirements
- R1: While `run_i` is low, `int_ready_o` and `byp_ready_o` are both 1, every descriptor offered is consumed, and none of them ever appears on the output.
- R2: A descriptor held in the output stage when `run_i` falls is still presented and delivered unchanged. Completions that arrive after the fall still retire outstanding work.
- R3: In the cycle where `run_i` rises, both input readies are 0. That edge clears the output stage, the outstanding count and the round-robin pointer, so the next contested grant goes to the internal source.
- R4: When both sources hold eligible descriptors, grants alternate. The pointer points at the internal source after reset and, after each grant, points at the source that was not granted.
- R5: When only one source has an eligible descriptor, that source is granted whatever the pointer says.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and `out_desc_o` stays stable. Descriptors leave in the order they were admitted, with no loss and no duplication.
- R7: `quiesce_o` is 1 exactly when `run_i` is 0, the output stage is empty and no issued descriptor is waiting for its `done_i` pulse.
- R8: While running, a bypass descriptor with `byp_int_mode_i` = 1 is accepted (`byp_ready_o` = 1) and dropped. `mode_err_o` is 1 for exactly the cycle after that acceptance.
- R9: At most `MAX_OUT` issued descriptors (default 4) lack a completion. While that many are outstanding, `out_valid_o` stays 0 even if the stage is full.
- R10: `out_src_o` is 0 for a descriptor that came from the internal input and 1 for one that came from the bypass input.
- R11: After reset, `out_valid_o` and `mode_err_o` are 0, and with `run_i` low both readies and `quiesce_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run-enable bit from software |
| int_valid_i | input | 1 | Internal-path descriptor valid |
| int_ready_o | output | 1 | Internal-path descriptor ready |
| int_desc_i | input | DESC_W | Internal-path descriptor |
| byp_valid_i | input | 1 | Bypass descriptor valid |
| byp_ready_o | output | 1 | Bypass descriptor ready |
| byp_desc_i | input | DESC_W | Bypass descriptor |
| byp_int_mode_i | input | 1 | Bypass descriptor targets an internal-mode queue |
| out_valid_o | output | 1 | Merged descriptor valid |
| out_ready_i | input | 1 | Downstream accepts merged descriptor |
| out_desc_o | output | DESC_W | Merged descriptor |
| out_src_o | output | 1 | Origin of merged descriptor (0 internal, 1 bypass) |
| done_i | input | 1 | One-cycle completion of one issued descriptor |
| quiesce_o | output | 1 | Engine stopped and drained |
| mode_err_o | output | 1 | Misrouted bypass descriptor pulse |

## Verification
The bench targets the moment the run bit falls while a descriptor sits in the output stage under backpressure. A design that flushed the stage on that edge would lose a descriptor that had already been admitted. It then re-enables the engine after leaving the pointer aimed at bypass. A design that failed to reset the pointer would grant bypass first when both sources collide. It also holds back completions until the outstanding limit is reached, and checks that `out_valid_o` stays low instead of pushing a fifth descriptor downstream. Finally it sends misrouted bypass descriptors and descriptors that arrive while the engine is stopped. A design that forwarded either would produce output the scoreboard never expected, and one that stalled would hang a source.

// File: rtl/dmerge_pkg.sv
package dmerge_pkg;
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_BYP = 1'b1
    } src_e;
endpackage

// File: rtl/dmerge_rr.sv
module dmerge_rr
    import dmerge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic req_int_i,
    input  logic req_byp_i,
    input  logic take_i,
    output logic gnt_int_o,
    output logic gnt_byp_o
);
    src_e ptr_d, ptr_q;

    always_comb begin
        gnt_int_o = 1'b0;
        gnt_byp_o = 1'b0;
        if (req_int_i && req_byp_i) begin
            gnt_int_o = (ptr_q == SRC_INT);
            gnt_byp_o = (ptr_q == SRC_BYP);
        end else begin
            gnt_int_o = req_int_i;
            gnt_byp_o = req_byp_i;
        end

        ptr_d = ptr_q;
        if (clr_i) begin
            ptr_d = SRC_INT;
        end else if (take_i) begin
            ptr_d = gnt_int_o ? SRC_BYP : SRC_INT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= SRC_INT;
        else        ptr_q <= ptr_d;
    end

    // R4: never both grants at once
    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_int_o, gnt_byp_o}));

    // R5: a lone requester always wins
    assert_lone_bypass_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_byp_i && !req_int_i) |-> gnt_byp_o);
endmodule

// File: rtl/dmerge_cnt.sv
module dmerge_cnt #(
    parameter int MAX = 4,
    localparam int CW = $clog2(MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    input  logic dec_i,
    output logic full_o,
    output logic zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          dec_ok;

    always_comb begin
        dec_ok = dec_i && (cnt_q != '0);
        cnt_d  = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && !dec_ok) begin
            cnt_d = cnt_q + 1'b1;
        end else if (!inc_i && dec_ok) begin
            cnt_d = cnt_q - 1'b1;
        end
        full_o = (cnt_q == CW'(MAX));
        zero_o = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: the outstanding count never passes its limit
    assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX));

    // R9: no issue is counted while already at the limit
    assert_no_issue_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !inc_i);
endmodule

// File: rtl/desc_merge_gate.sv
module desc_merge_gate
    import dmerge_pkg::*;
#(
    parameter int DESC_W  = 32,
    parameter int MAX_OUT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              int_valid_i,
    output logic              int_ready_o,
    input  logic [DESC_W-1:0] int_desc_i,
    input  logic              byp_valid_i,
    output logic              byp_ready_o,
    input  logic [DESC_W-1:0] byp_desc_i,
    input  logic              byp_int_mode_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DESC_W-1:0] out_desc_o,
    output logic              out_src_o,
    input  logic              done_i,
    output logic              quiesce_o,
    output logic              mode_err_o
);
    typedef struct packed {
        logic              run;
        logic              stg_v;
        src_e              stg_src;
        logic [DESC_W-1:0] stg_desc;
        logic              err;
    } state_t;

    state_t s_d, s_q;

    logic rise, active, issue, fire, slot_free, take;
    logic gnt_int, gnt_byp, cnt_full, cnt_zero;

    dmerge_rr u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (rise),
        .req_int_i (int_valid_i),
        .req_byp_i (byp_valid_i && !byp_int_mode_i),
        .take_i    (take),
        .gnt_int_o (gnt_int),
        .gnt_byp_o (gnt_byp)
    );

    dmerge_cnt #(.MAX(MAX_OUT)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (rise),
        .inc_i  (fire),
        .dec_i  (done_i),
        .full_o (cnt_full),
        .zero_o (cnt_zero)
    );

    always_comb begin
        rise      = run_i && !s_q.run;
        active    = run_i && s_q.run;
        issue     = s_q.stg_v && !cnt_full;
        fire      = issue && out_ready_i;
        slot_free = !s_q.stg_v || fire;
        take      = active && slot_free && (gnt_int || gnt_byp);

        int_ready_o = !run_i || (active && slot_free && gnt_int);
        byp_ready_o = !run_i || (active && (byp_int_mode_i || (slot_free && gnt_byp)));

        s_d     = s_q;
        s_d.run = run_i;
        s_d.err = 1'b0;
        if (rise) begin
            s_d.stg_v = 1'b0;
        end else begin
            if (fire) s_d.stg_v = 1'b0;
            if (take) begin
                s_d.stg_v    = 1'b1;
                s_d.stg_desc = gnt_int ? int_desc_i : byp_desc_i;
                s_d.stg_src  = gnt_int ? SRC_INT : SRC_BYP;
            end
            s_d.err = active && byp_valid_i && byp_int_mode_i;
        end

        out_valid_o = issue;
        out_desc_o  = s_q.stg_desc;
        out_src_o   = s_q.stg_src;
        quiesce_o   = !run_i && !s_q.stg_v && cnt_zero;
        mode_err_o  = s_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: a stalled output holds its descriptor
    assert_stage_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> ((out_valid_o && $stable(out_desc_o)) || rise));

    // R1: nothing enters an empty stage while stopped
    assert_no_admit_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !s_q.stg_v) |=> !s_q.stg_v);

    // R3: the enabling edge empties the stage
    assert_rise_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !s_q.stg_v);

    // R7: a quiesced engine offers nothing
    assert_quiesce_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        quiesce_o |-> !out_valid_o);

    // R8: an error pulse follows a misrouted bypass descriptor while running
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> $past(byp_valid_i && byp_int_mode_i && run_i));
endmodule

// File: tb/desc_merge_gate_tb_top.sv
module desc_merge_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int DW         = 32;
    localparam int LIMIT      = 4;

    typedef struct {
        logic [DW-1:0] d;
        logic          s;
    } exp_t;

    logic          clk, rst_n, run;
    logic          int_valid, int_ready, byp_valid, byp_ready, byp_mode;
    logic [DW-1:0] int_desc, byp_desc, out_desc;
    logic          out_valid, out_ready, out_src, done, quiesce, mode_err;

    exp_t exp_q[$];
    logic src_log[$];
    int   checks = 0, failures = 0, fires = 0, outstanding = 0;
    bit   done_en = 0;

    desc_merge_gate #(.DESC_W(DW), .MAX_OUT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .int_valid_i(int_valid), .int_ready_o(int_ready), .int_desc_i(int_desc),
        .byp_valid_i(byp_valid), .byp_ready_o(byp_ready), .byp_desc_i(byp_desc),
        .byp_int_mode_i(byp_mode),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_desc_o(out_desc),
        .out_src_o(out_src), .done_i(done), .quiesce_o(quiesce), .mode_err_o(mode_err)
    );

    initial clk = 1'b0;
    always #(HALF) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic smp(); #(HALF - 1); endtask
    task automatic nxt(); @(negedge clk); endtask

    task automatic send_int(input logic [DW-1:0] d);
        bit acc = 0;
        int_valid = 1'b1;
        int_desc  = d;
        while (!acc) begin
            smp();
            if (int_ready) begin
                acc = 1;
                if (run) exp_q.push_back('{d: d, s: 1'b0});
            end
            nxt();
        end
        int_valid = 1'b0;
    endtask

    task automatic send_byp(input logic [DW-1:0] d, input logic mode);
        bit acc = 0;
        byp_valid = 1'b1;
        byp_desc  = d;
        byp_mode  = mode;
        while (!acc) begin
            smp();
            if (byp_ready) begin
                acc = 1;
                if (run && !mode) exp_q.push_back('{d: d, s: 1'b1});
            end
            nxt();
        end
        byp_valid = 1'b0;
        byp_mode  = 1'b0;
    endtask

    // scoreboard monitor (R6, R10)
    always begin
        @(negedge clk);
        #(HALF - 1);
        if (rst_n && out_valid && out_ready) begin
            exp_t e;
            fires++;
            outstanding++;
            src_log.push_back(out_src);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected output", out_desc, 0);
            end else begin
                e = exp_q.pop_front();
                chk(out_desc == e.d, "R6", "desc order", out_desc, e.d);
                chk(out_src == e.s, "R10", "source tag", out_src, e.s);
            end
        end
    end

    // completion generator
    always @(negedge clk) begin
        if (done_en && outstanding > 0) begin
            done = 1'b1;
            outstanding--;
        end else begin
            done = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        finish_sim();
    end

    initial begin
        int base;
        rst_n = 0; run = 0; int_valid = 0; byp_valid = 0; byp_mode = 0;
        int_desc = '0; byp_desc = '0; out_ready = 0; done = 0;
        repeat (3) nxt();
        rst_n = 1;

        // R11 reset state
        smp();
        chk(out_valid == 0, "R11", "out_valid after reset", out_valid, 0);
        chk(mode_err == 0, "R11", "mode_err after reset", mode_err, 0);
        chk(int_ready && byp_ready, "R11", "readies while stopped", {int_ready, byp_ready}, 2'b11);
        chk(quiesce == 1, "R7", "quiesce idle stopped", quiesce, 1);
        nxt();

        // R1 drops while stopped
        out_ready = 1;
        fork
            send_int(32'hA1);
            send_byp(32'hB1, 1'b0);
        join
        repeat (3) begin
            smp();
            chk(out_valid == 0, "R1", "dropped desc emitted", out_valid, 0);
            nxt();
        end

        // R3 rise cycle blocks admission
        run = 1;
        smp();
        chk(!int_ready && !byp_ready, "R3", "ready during rise", {int_ready, byp_ready}, 0);
        nxt();

        // R5 single sources
        done_en = 1;
        for (int i = 0; i < 3; i++) send_int(32'h10 + i);
        for (int i = 0; i < 3; i++) send_byp(32'h20 + i, 1'b0);
        repeat (4) nxt();

        // R4 contested round robin
        src_log.delete();
        fork
            for (int i = 0; i < 4; i++) send_int(32'h40 + i);
            for (int i = 0; i < 4; i++) send_byp(32'h50 + i, 1'b0);
        join
        repeat (4) nxt();
        chk(src_log.size() == 8, "R4", "contested count", src_log.size(), 8);
        for (int i = 0; i < 8 && i < src_log.size(); i++)
            chk(src_log[i] == 1'(i % 2), "R4", "alternation", src_log[i], i % 2);

        // R6 hold under backpressure
        out_ready = 0;
        send_int(32'hC0);
        repeat (3) begin
            smp();
            chk(out_valid && out_desc == 32'hC0, "R6", "held desc", out_desc, 32'hC0);
            nxt();
        end
        out_ready = 1;
        repeat (6) nxt();

        // R2 drain after run falls
        done_en = 0;
        out_ready = 0;
        send_byp(32'hD0, 1'b0);
        run = 0;
        repeat (2) begin
            smp();
            chk(out_valid && out_desc == 32'hD0, "R2", "admitted desc kept", out_desc, 32'hD0);
            chk(quiesce == 0, "R7", "busy not quiesced", quiesce, 0);
            nxt();
        end
        out_ready = 1;
        smp(); nxt();
        smp();
        chk(out_valid == 0 && quiesce == 0, "R7", "outstanding blocks quiesce", quiesce, 0);
        nxt();
        done_en = 1;
        repeat (3) nxt();
        smp();
        chk(quiesce == 1, "R2", "completion after fall drains", quiesce, 1);
        nxt();

        // R9 outstanding limit
        run = 1;
        done_en = 0;
        base = fires;
        fork
            for (int i = 0; i < 6; i++) send_int(32'h60 + i);
            begin
                repeat (12) nxt();
                smp();
                chk(fires - base == LIMIT, "R9", "issued at limit", fires - base, LIMIT);
                chk(out_valid == 0, "R9", "valid held low at limit", out_valid, 0);
                nxt();
                done_en = 1;
            end
        join
        repeat (8) nxt();

        // R3 pointer reset by enabling edge (pointer now at bypass)
        run = 0;
        repeat (6) nxt();
        smp();
        chk(quiesce == 1, "R7", "quiesced before restart", quiesce, 1);
        nxt();
        run = 1;
        src_log.delete();
        fork
            send_int(32'h80);
            send_byp(32'h90, 1'b0);
        join
        repeat (3) nxt();
        chk(src_log.size() == 2 && src_log[0] == 1'b0, "R3", "first grant after restart",
            src_log.size() > 0 ? src_log[0] : 1'b1, 0);

        // R8 misrouted bypass
        send_byp(32'hE0, 1'b1);
        smp();
        chk(mode_err == 1, "R8", "error pulse", mode_err, 1);
        nxt();
        smp();
        chk(mode_err == 0, "R8", "pulse one cycle", mode_err, 0);
        chk(out_valid == 0, "R8", "misrouted not forwarded", out_valid, 0);
        nxt();

        repeat (10) nxt();
        chk(exp_q.size() == 0, "R1", "expected items left", exp_q.size(), 0);
        finish_sim();
    end
endmodule